// File: doc/BRIEF.md
# SDRAM Read Access Sequencer

This block turns read requests into the command stream that a single-rank SDRAM device expects. It remembers which row is open in each bank. For each request it either reads at once (page hit), or opens a row in a closed bank, or closes the open row in the bank and opens the new one before reading. It counts the precharge-to-activate and activate-to-read gaps from configuration inputs. It waits out the read latency and flags each returned beat with a valid strobe.

The device always delivers bursts of eight beats. When a request asks for fewer beats, the sequencer places a burst stop command so that only the wanted beats arrive. A request marked sequential continues on the bank and row of the previous read and skips the row check. A request without that mark is checked again against the open-row record. Refresh, writes, initialization and data capture are handled elsewhere.

Top module: `sdram_rd_seq`

## Requirements
- R1: During and right after reset, `mem_cmd` is NOP (code 0), `rd_valid` is low and `req_ready` is high.
- R2: After reset every bank counts as closed. The first request to a bank gives ACT (code 1) in the cycle after acceptance, with `mem_addr` = row, and then RD (code 2) with `mem_addr` = column. No PRE (code 3) is issued.
- R3: A request whose bank holds the same open row gives RD in the cycle after acceptance.
- R4: A request whose bank holds a different open row gives PRE, then ACT of the new row, then RD, all on that bank.
- R5: ACT follows PRE after exactly `cfg_trp` cycles. A value of 0 counts as 1.
- R6: RD follows ACT after exactly `cfg_trcd` cycles. A value of 0 counts as 1.
- R7: `rd_valid` first rises 2 cycles after the RD cycle when `cfg_lat_sel` = 0, and 3 cycles after it for codes 1, 2 and 3 (code 1 is the half-cycle setting).
- R8: For 1 to 7 beats, BST (code 4) appears exactly that many cycles after RD, and `rd_valid` stays high for exactly that many consecutive cycles.
- R9: A beat count of 8, 0 or above 8 gives 8 valid beats and no BST.
- R10: With `req_seq` high and an earlier read since reset, RD goes out in the cycle after acceptance to the previous bank, with the new column. `req_bank` and `req_row` are ignored. With no earlier read, the request is evaluated as a normal one.
- R11: `req_ready` is low from the cycle after acceptance until the cycle just after the last valid beat. Every cycle that carries no command carries NOP.
- R12: Each bank keeps its own open row. Opening a row in one bank leaves the rows open in the other banks as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | BANK_W | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Starting column |
| req_beats | input | BEAT_W | Beats wanted (1..8; 0 or more than 8 means 8) |
| req_seq | input | 1 | Continue on the previous bank and row |
| cfg_lat_sel | input | 2 | Read latency code: 0 = 2 clocks, other codes = 3 clocks |
| cfg_trp | input | TIM_W | Precharge-to-activate gap in clocks |
| cfg_trcd | input | TIM_W | Activate-to-read gap in clocks |
| mem_cmd | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 PRE, 4 BST |
| mem_ba | output | BANK_W | Bank address for the command |
| mem_addr | output | ADDR_W | Row for ACT, column for RD, zero otherwise |
| rd_valid | output | 1 | A wanted data beat arrives this cycle |

## Verification
The bench uses the default parameters: four banks, 13-bit rows, 10-bit columns, a burst of eight and 4-bit gap counters. With four banks, a hit in one bank can follow an activate in another, which tests the per-bank row record. The 4-bit gap inputs let the bench drive 0 (counted as 1) and gaps up to 4. The 4-bit beat field lets it drive 0 and 9 as well as 1 to 8, so the length handling is tested on both sides of the burst size, with every latency code.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_BST = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PRE_WAIT = 2'd1,
        ST_ACT_WAIT = 2'd2,
        ST_DATA     = 2'd3
    } state_e;

endpackage

// File: rtl/rdseq_rowtab.sv
module rdseq_rowtab #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    output logic              open_vld,
    output logic [ROW_W-1:0]  open_row
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] vld_d, vld_q;
    logic [ROW_W-1:0] row_d [NBANK];
    logic [ROW_W-1:0] row_q [NBANK];

    // one entry per bank; only the written bank changes
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            vld_d[b] = vld_q[b];
            row_d[b] = row_q[b];
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                vld_d[b] = 1'b1;
                row_d[b] = wr_row;
            end
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                row_q[g] <= '0;
            end else begin
                vld_q[g] <= vld_d[g];
                row_q[g] <= row_d[g];
            end
        end
    end

    assign open_vld = vld_q[lk_bank];
    assign open_row = row_q[lk_bank];

    // R12
    tab_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_bank)] && row_q[$past(wr_bank)] == $past(wr_row)));

endmodule

// File: rtl/rdseq_beat.sv
module rdseq_beat #(
    parameter int BURST  = 8,
    parameter int BEAT_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BEAT_W-1:0] beats_i,
    input  logic [CNT_W-1:0]  lat_i,
    output logic              bst_o,
    output logic              done_o,
    output logic              valid_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } beat_t;

    beat_t q, d;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] beats_w;

    assign nxt     = q.cnt + CNT_W'(1);
    assign beats_w = CNT_W'(beats_i);

    assign bst_o  = q.active && (nxt == beats_w) && (beats_i < BEAT_W'(BURST));
    assign done_o = q.active && (nxt == lat_i + beats_w);

    always_comb begin
        d = q;
        if (start_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.valid  = 1'b0;
        end else if (q.active) begin
            d.cnt    = nxt;
            d.valid  = (nxt >= lat_i) && (nxt < lat_i + beats_w);
            if (done_o) begin
                d.active = 1'b0;
            end
        end else begin
            d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.valid;

    // R7
    lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o);

    // R11
    data_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import rdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BURST  = 8,
    parameter int TIM_W  = 4,
    parameter int BEAT_W = $clog2(BURST) + 1,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_seq,
    input  logic [1:0]        cfg_lat_sel,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic [TIM_W-1:0]  cfg_trcd,
    output logic [2:0]        mem_cmd,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid
);
    localparam int CNT_W = BEAT_W + 1;

    typedef struct packed {
        state_e            state;
        logic [TIM_W-1:0]  timer;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BEAT_W-1:0] beats;
        logic [CNT_W-1:0]  lat;
        cmd_e              cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic              last_v;
        logic [BANK_W-1:0] last_bank;
        logic [ROW_W-1:0]  last_row;
    } seq_t;

    seq_t q, d;

    logic              use_last;
    logic [BANK_W-1:0] eff_bank;
    logic [ROW_W-1:0]  eff_row;
    logic [BANK_W-1:0] lk_bank;
    logic              open_vld;
    logic [ROW_W-1:0]  open_row;
    logic              tab_we;
    logic              start;
    logic              bst_req;
    logic              done_req;
    logic              beat_valid;
    logic [TIM_W-1:0]  trp_m1;
    logic [TIM_W-1:0]  trcd_m1;
    logic [BEAT_W-1:0] beats_eff;

    assign use_last  = req_seq && q.last_v;
    assign eff_bank  = use_last ? q.last_bank : req_bank;
    assign eff_row   = use_last ? q.last_row  : req_row;
    assign lk_bank   = (q.state == ST_IDLE) ? eff_bank : q.bank;
    assign trp_m1    = (cfg_trp  == '0) ? '0 : cfg_trp  - TIM_W'(1);
    assign trcd_m1   = (cfg_trcd == '0) ? '0 : cfg_trcd - TIM_W'(1);
    assign beats_eff = ((req_beats == '0) || (req_beats > BEAT_W'(BURST)))
                       ? BEAT_W'(BURST) : req_beats;

    rdseq_rowtab #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (lk_bank),
        .wr_en    (tab_we),
        .wr_bank  (q.bank),
        .wr_row   (q.row),
        .open_vld (open_vld),
        .open_row (open_row)
    );

    rdseq_beat #(
        .BURST  (BURST),
        .BEAT_W (BEAT_W),
        .CNT_W  (CNT_W)
    ) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .beats_i (q.beats),
        .lat_i   (q.lat),
        .bst_o   (bst_req),
        .done_o  (done_req),
        .valid_o (beat_valid)
    );

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.ba   = '0;
        d.addr = '0;
        tab_we = 1'b0;
        start  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.bank  = eff_bank;
                    d.row   = eff_row;
                    d.col   = req_col;
                    d.beats = beats_eff;
                    d.lat   = (cfg_lat_sel == 2'd0) ? CNT_W'(2) : CNT_W'(3);
                    if (use_last || (open_vld && open_row == eff_row)) begin
                        d.cmd       = CMD_RD;
                        d.ba        = eff_bank;
                        d.addr      = ADDR_W'(req_col);
                        d.state     = ST_DATA;
                        d.last_v    = 1'b1;
                        d.last_bank = eff_bank;
                        d.last_row  = eff_row;
                        start       = 1'b1;
                    end else if (open_vld) begin
                        d.cmd   = CMD_PRE;
                        d.ba    = eff_bank;
                        d.timer = trp_m1;
                        d.state = ST_PRE_WAIT;
                    end else begin
                        d.cmd   = CMD_ACT;
                        d.ba    = eff_bank;
                        d.addr  = ADDR_W'(eff_row);
                        d.timer = trcd_m1;
                        d.state = ST_ACT_WAIT;
                    end
                end
            end
            ST_PRE_WAIT: begin
                if (q.timer == '0) begin
                    d.cmd   = CMD_ACT;
                    d.ba    = q.bank;
                    d.addr  = ADDR_W'(q.row);
                    d.timer = trcd_m1;
                    d.state = ST_ACT_WAIT;
                end else begin
                    d.timer = q.timer - TIM_W'(1);
                end
            end
            ST_ACT_WAIT: begin
                if (q.state == ST_ACT_WAIT && q.cmd == CMD_ACT) begin
                    tab_we = 1'b1;
                end
                if (q.timer == '0) begin
                    d.cmd       = CMD_RD;
                    d.ba        = q.bank;
                    d.addr      = ADDR_W'(q.col);
                    d.state     = ST_DATA;
                    d.last_v    = 1'b1;
                    d.last_bank = q.bank;
                    d.last_row  = q.row;
                    start       = 1'b1;
                end else begin
                    d.timer = q.timer - TIM_W'(1);
                end
            end
            ST_DATA: begin
                if (bst_req) begin
                    d.cmd = CMD_BST;
                end
                if (done_req) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cmd   <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign mem_cmd   = q.cmd;
    assign mem_ba    = q.ba;
    assign mem_addr  = q.addr;
    assign rd_valid  = beat_valid;

    // R5
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_PRE) |=> (q.cmd != CMD_RD && q.cmd != CMD_PRE));

    // R6
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_ACT) |=> (q.cmd == CMD_NOP || q.cmd == CMD_RD));

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    bst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_BST) |-> (q.state == ST_DATA && !req_ready));

endmodule

// File: tb/sim_sdram_rd_seq.sv
module sim_sdram_rd_seq;
    localparam int PERIOD = 10;
    localparam int NVEC   = 10;

    typedef struct packed {
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic [3:0]  beats;
        logic        seq;
        logic [1:0]  cl;
        logic [3:0]  trp;
        logic [3:0]  trcd;
        logic [1:0]  kind;   // 0 hit, 1 activate only, 2 precharge+activate
        logic [1:0]  ebank;  // bank expected on the read
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 13'd5,   10'd8,  4'd1, 1'b0, 2'd0, 4'd1, 4'd1, 2'd1, 2'd0},
        '{2'd0, 13'd5,   10'd16, 4'd8, 1'b0, 2'd1, 4'd2, 4'd2, 2'd0, 2'd0},
        '{2'd0, 13'd9,   10'd0,  4'd3, 1'b0, 2'd2, 4'd3, 4'd2, 2'd2, 2'd0},
        '{2'd1, 13'd9,   10'd4,  4'd7, 1'b0, 2'd0, 4'd2, 4'd3, 2'd1, 2'd1},
        '{2'd0, 13'd9,   10'd12, 4'd4, 1'b0, 2'd3, 4'd1, 4'd1, 2'd0, 2'd0},
        '{2'd2, 13'd7,   10'd20, 4'd2, 1'b1, 2'd0, 4'd1, 4'd1, 2'd0, 2'd0},
        '{2'd1, 13'd1,   10'd0,  4'd0, 1'b0, 2'd1, 4'd4, 4'd1, 2'd2, 2'd1},
        '{2'd1, 13'd1,   10'd2,  4'd9, 1'b0, 2'd0, 4'd1, 4'd4, 2'd0, 2'd1},
        '{2'd3, 13'd100, 10'd0,  4'd5, 1'b0, 2'd2, 4'd0, 4'd0, 2'd1, 2'd3},
        '{2'd3, 13'd200, 10'd0,  4'd6, 1'b0, 2'd0, 4'd0, 4'd2, 2'd2, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [3:0]  req_beats = '0;
    logic        req_seq = 1'b0;
    logic [1:0]  cfg_lat_sel = '0;
    logic [3:0]  cfg_trp = 4'd1;
    logic [3:0]  cfg_trcd = 4'd1;
    logic [2:0]  mem_cmd;
    logic [1:0]  mem_ba;
    logic [12:0] mem_addr;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sdram_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_beats(req_beats), .req_seq(req_seq), .cfg_lat_sel(cfg_lat_sel),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .mem_cmd(mem_cmd),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .rd_valid(rd_valid)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run_req(input vec_t v, input int id);
        int effb, lat, tp, tc;
        int pre_k, act_k, rd_k, bst_k, ncmd;
        int o_pre, o_act, o_rd, o_bst, o_ncmd, o_vfirst, o_vcnt, o_rdy;
        int o_ba, o_addr, o_actaddr;
        effb = (v.beats == 0 || v.beats > 8) ? 8 : int'(v.beats);
        lat  = (v.cl == 0) ? 2 : 3;
        tp   = (v.trp == 0) ? 1 : int'(v.trp);
        tc   = (v.trcd == 0) ? 1 : int'(v.trcd);
        pre_k = -1; act_k = -1;
        if (v.kind == 2) begin pre_k = 1; act_k = 1 + tp; rd_k = act_k + tc; end
        else if (v.kind == 1) begin act_k = 1; rd_k = 1 + tc; end
        else rd_k = 1;
        bst_k = (effb < 8) ? rd_k + effb : -1;
        ncmd  = 1 + (pre_k > 0 ? 1 : 0) + (act_k > 0 ? 1 : 0) + (bst_k > 0 ? 1 : 0);

        for (int w = 0; w < 40 && !req_ready; w++) @(negedge clk);
        req_bank = v.bank; req_row = v.row; req_col = v.col; req_beats = v.beats;
        req_seq = v.seq; cfg_lat_sel = v.cl; cfg_trp = v.trp; cfg_trcd = v.trcd;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        o_pre = -1; o_act = -1; o_rd = -1; o_bst = -1; o_ncmd = 0;
        o_vfirst = -1; o_vcnt = 0; o_rdy = -1; o_ba = -1; o_addr = -1; o_actaddr = -1;
        for (int k = 1; k <= 48; k++) begin
            if (mem_cmd != 3'd0) o_ncmd++;
            if (mem_cmd == 3'd3 && o_pre < 0) o_pre = k;
            if (mem_cmd == 3'd1 && o_act < 0) begin o_act = k; o_actaddr = int'(mem_addr); end
            if (mem_cmd == 3'd2 && o_rd < 0) begin o_rd = k; o_ba = int'(mem_ba); o_addr = int'(mem_addr); end
            if (mem_cmd == 3'd4 && o_bst < 0) o_bst = k;
            if (rd_valid) begin o_vcnt++; if (o_vfirst < 0) o_vfirst = k; end
            if (req_ready) begin o_rdy = k; break; end
            req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check($sformatf("R4 vec%0d PRE cycle", id), o_pre, pre_k);
        check($sformatf("R2 R5 vec%0d ACT cycle", id), o_act, act_k);
        if (act_k > 0) check($sformatf("R2 vec%0d ACT row", id), o_actaddr, int'(v.row));
        check($sformatf("R3 R6 vec%0d RD cycle", id), o_rd, rd_k);
        check($sformatf("R10 vec%0d RD bank", id), o_ba, int'(v.ebank));
        check($sformatf("R10 vec%0d RD column", id), o_addr, int'(v.col));
        check($sformatf("R8 R9 vec%0d BST cycle", id), o_bst, bst_k);
        check($sformatf("R7 vec%0d first valid", id), o_vfirst, rd_k + lat);
        check($sformatf("R8 R9 vec%0d valid beats", id), o_vcnt, effb);
        check($sformatf("R11 vec%0d ready cycle", id), o_rdy, rd_k + lat + effb);
        check($sformatf("R11 vec%0d command count", id), o_ncmd, ncmd);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 cmd in reset", int'(mem_cmd), 0);
        check("R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cmd after reset", int'(mem_cmd), 0);
        check("R1 valid after reset", int'(rd_valid), 0);
        check("R1 ready after reset", int'(req_ready), 1);

        for (int i = 0; i < NVEC; i++) run_req(TBL[i], i);

        // R10 sequential flag with no history: evaluated normally, opens bank 2
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_req('{2'd2, 13'd3, 10'd1, 4'd2, 1'b1, 2'd0, 4'd1, 4'd1, 2'd1, 2'd2}, 100);
        // R12 bank 2 now open on row 3: a hit on it
        run_req('{2'd2, 13'd3, 10'd5, 4'd1, 1'b0, 2'd1, 4'd1, 4'd1, 2'd0, 2'd2}, 101);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule